// File: doc/BRIEF.md
# Pixel Clock PLL Reprogramming Sequencer

This block takes a requested pixel clock frequency in kHz, finds the closest entry in a small built-in table of frequency and PLL setting pairs, and then reprograms the pixel clock PLL without disturbing it more than needed. If the PLL is already locked on the chosen setting, nothing is written. Otherwise the block loads the new setting and clears the bypass and half-pixel controls in one update, holding the PLL in reset at the same moment. It waits a fixed settle time and then samples the lock flag once per clock for a bounded number of samples. Reset is released as soon as lock is seen, or when the sample budget runs out. In the second case a timeout flag is raised.

The table holds `N_TAB` entries sorted by ascending frequency. Both columns are computed by package functions. Entry i has frequency 6000 + 1500·i + 250·i² kHz, so 25175 means 25.175 MHz. The settle time is `SETTLE_US` microseconds, counted in core clocks through `CYC_PER_US`. The lock sample budget is `POLL_MAX`. The analog PLL sits outside the block and answers through `pll_lock`.

Top module: `pxclk_pll_seq`

## Requirements
- R1: The chosen entry has the smallest absolute difference |table kHz − req_khz|. Entries are compared with strict less-than in ascending index order, so on a tie the lower index wins.
- R2: The applied setting is the table setting ANDed with 0x00017FFF.
- R3: If, at decision time, pll_lock is 1 and pll_setting already equals the masked chosen setting, the run ends with done and makes no write: pll_wr stays 0, pll_rst stays 0 and pll_setting is unchanged.
- R4: Otherwise, in one clock: pll_setting takes the new value, pll_bypass and pll_halfpix go to 0, pll_rst goes to 1, and pll_wr pulses for exactly one cycle.
- R5: After pll_rst rises, the lock flag is first sampled after SETTLE_US·CYC_PER_US clocks. If lock is already present at that point, pll_rst stays high for exactly SETTLE_US·CYC_PER_US + 1 clocks.
- R6: Lock is sampled once per clock. pll_rst falls on the first clock edge that samples pll_lock = 1.
- R7: If POLL_MAX samples all show no lock, pll_rst falls after the last one and timeout is set to 1. A lock seen on the final sample is not a timeout.
- R8: timeout is cleared to 0 when the next start is accepted.
- R9: A start pulse while busy is 1 is ignored. The running request and its result are unaffected, and no extra done is produced.
- R10: During reset: busy=0, done=0, timeout=0, pll_rst=0, pll_wr=0, pll_bypass=1, pll_halfpix=0, pll_setting=INIT_SETTING (0).
- R11: busy is 1 from the clock after start is accepted until the run ends. done is a one-cycle pulse during which busy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request strobe, accepted when not busy |
| req_khz | input | 20 | Requested pixel clock in kHz, sampled with start |
| pll_lock | input | 1 | Lock flag from the PLL |
| pll_setting | output | 32 | Setting word driven to the PLL |
| pll_bypass | output | 1 | PLL bypass control |
| pll_halfpix | output | 1 | Half-pixel divider control |
| pll_rst | output | 1 | PLL reset control |
| pll_wr | output | 1 | One-cycle strobe marking a setting update |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| timeout | output | 1 | Last run ended without lock |

## Verification
The bench targets several boundary cases. A request exactly midway between two entries is expected to pick the lower entry; a design that compares with less-or-equal would pick the upper one. A repeat request while the PLL is locked is expected to produce no write; a design that drops the skip check, or ignores the lock condition, would pulse pll_wr or hold reset. Lock is made to arrive at four points: early, mid-poll, exactly on the last allowed sample, and never. Each case has an exact expected reset-high length, so a wrong settle count, an off-by-one poll budget or a missing release shows up as a wrong length or a wrong timeout. A start injected mid-run checks that a design re-latching the request would land on a different setting or raise an extra done.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  localparam int KHZ_W = 20;
  localparam int SET_W = 32;
  localparam logic [SET_W-1:0] SET_MASK = 32'h0001_7FFF;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCAN,
    ST_DECIDE,
    ST_SETTLE,
    ST_POLL,
    ST_FIN
  } seq_st_e;

  // Entry frequency in kHz, ascending; valid for indices below 60.
  function automatic logic [KHZ_W-1:0] tab_khz(input int unsigned i);
    return KHZ_W'(6000 + 1500 * i + 250 * i * i);
  endfunction

  // Raw setting word for an entry, before masking.
  function automatic logic [SET_W-1:0] tab_set(input int unsigned i);
    return 32'hC3A0_0000 | ((32'(i) * 32'h0000_1A2B) ^ 32'h0001_0450);
  endfunction

  function automatic logic [SET_W-1:0] mask_set(input logic [SET_W-1:0] s);
    return s & SET_MASK;
  endfunction

  function automatic logic [KHZ_W-1:0] khz_dist(input logic [KHZ_W-1:0] a,
                                                 input logic [KHZ_W-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

endpackage

// File: rtl/pll_tab_search.sv
module pll_tab_search
  import pll_seq_pkg::*;
#(
  parameter int N_TAB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [KHZ_W-1:0] req_khz,
  output logic             found,
  output logic [SET_W-1:0] best_set,
  output logic [KHZ_W-1:0] req_held
);
  localparam int IW = (N_TAB > 1) ? $clog2(N_TAB) : 1;
  localparam logic [IW-1:0] LAST_IDX = IW'(N_TAB - 1);

  logic [KHZ_W-1:0] rom_khz [N_TAB];
  logic [SET_W-1:0] rom_set [N_TAB];

  for (genvar g = 0; g < N_TAB; g++) begin : g_rom
    assign rom_khz[g] = tab_khz(g);
    assign rom_set[g] = mask_set(tab_set(g));
  end

  logic             scanning;
  logic [IW-1:0]    idx;
  logic [IW-1:0]    best_idx;
  logic [KHZ_W-1:0] best_diff;
  logic [KHZ_W-1:0] cur_diff;
  logic             take;

  assign cur_diff = khz_dist(rom_khz[idx], req_held);
  assign take     = cur_diff < best_diff;
  assign best_set = rom_set[best_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scanning  <= 1'b0;
      idx       <= '0;
      best_idx  <= '0;
      best_diff <= '1;
      req_held  <= '0;
      found     <= 1'b0;
    end else if (go) begin
      scanning  <= 1'b1;
      idx       <= '0;
      best_idx  <= '0;
      best_diff <= '1;
      req_held  <= req_khz;
      found     <= 1'b0;
    end else if (scanning) begin
      if (take) begin
        best_idx  <= idx;
        best_diff <= cur_diff;
      end
      if (idx == LAST_IDX) begin
        scanning <= 1'b0;
        found    <= 1'b1;
      end else begin
        idx <= idx + 1'b1;
      end
    end else begin
      found <= 1'b0;
    end
  end

  // R1
  best_shrinks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scanning && !go) |=> (best_diff <= $past(best_diff)));

endmodule

// File: rtl/pll_seq_cnt.sv
module pll_seq_cnt #(
  parameter int LIMIT = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic last
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST_VAL = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign last = (cnt == LAST_VAL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (en && !last) cnt <= cnt + 1'b1;
  end

  // R5
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter logic [SET_W-1:0] INIT_SETTING = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             found,
  input  logic [SET_W-1:0] best_set,
  input  logic             pll_lock,
  input  logic             settle_last,
  input  logic             poll_last,
  output logic             go,
  output logic             cnt_clr,
  output logic             settle_en,
  output logic             poll_en,
  output logic [SET_W-1:0] pll_setting,
  output logic             pll_bypass,
  output logic             pll_halfpix,
  output logic             pll_rst,
  output logic             pll_wr,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  seq_st_e st;
  logic    skip_hit;

  assign busy      = (st != ST_IDLE) && (st != ST_FIN);
  assign done      = (st == ST_FIN);
  assign go        = start && !busy;
  assign cnt_clr   = (st == ST_DECIDE);
  assign settle_en = (st == ST_SETTLE);
  assign poll_en   = (st == ST_POLL);
  assign skip_hit  = (st == ST_DECIDE) && pll_lock && (pll_setting == best_set);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      pll_setting <= INIT_SETTING;
      pll_bypass  <= 1'b1;
      pll_halfpix <= 1'b0;
      pll_rst     <= 1'b0;
      pll_wr      <= 1'b0;
      timeout     <= 1'b0;
    end else begin
      pll_wr <= 1'b0;
      unique case (st)
        ST_IDLE, ST_FIN: begin
          if (start) begin
            st      <= ST_SCAN;
            timeout <= 1'b0;
          end else begin
            st <= ST_IDLE;
          end
        end
        ST_SCAN: if (found) st <= ST_DECIDE;
        ST_DECIDE: begin
          if (skip_hit) begin
            st <= ST_FIN;
          end else begin
            pll_setting <= best_set;
            pll_bypass  <= 1'b0;
            pll_halfpix <= 1'b0;
            pll_rst     <= 1'b1;
            pll_wr      <= 1'b1;
            st          <= ST_SETTLE;
          end
        end
        ST_SETTLE: if (settle_last) st <= ST_POLL;
        ST_POLL: begin
          if (pll_lock) begin
            pll_rst <= 1'b0;
            st      <= ST_FIN;
          end else if (poll_last) begin
            pll_rst <= 1'b0;
            timeout <= 1'b1;
            st      <= ST_FIN;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R3
  skip_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_hit |=> (done && !pll_rst && !pll_wr && $stable(pll_setting)));

  // R4
  wr_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pll_wr |-> (pll_rst && !pll_bypass && !pll_halfpix && $past(st == ST_DECIDE)));

  // R5
  settle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    settle_en |-> pll_rst);

  // R6
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (poll_en && pll_lock) |=> (!pll_rst && done && !timeout));

  // R7
  timeout_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(timeout) |-> $fell(pll_rst));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (!done && !busy));

endmodule

// File: rtl/pxclk_pll_seq.sv
module pxclk_pll_seq
  import pll_seq_pkg::*;
#(
  parameter int               N_TAB        = 16,
  parameter int               CYC_PER_US   = 50,
  parameter int               SETTLE_US    = 100,
  parameter int               POLL_MAX     = 1000,
  parameter logic [SET_W-1:0] INIT_SETTING = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [KHZ_W-1:0] req_khz,
  input  logic             pll_lock,
  output logic [SET_W-1:0] pll_setting,
  output logic             pll_bypass,
  output logic             pll_halfpix,
  output logic             pll_rst,
  output logic             pll_wr,
  output logic             busy,
  output logic             done,
  output logic             timeout
);
  localparam int SETTLE_CYC = CYC_PER_US * SETTLE_US;

  logic             go;
  logic             found;
  logic [SET_W-1:0] best_set;
  logic [KHZ_W-1:0] req_held;
  logic             cnt_clr;
  logic             settle_en;
  logic             poll_en;
  logic             settle_last;
  logic             poll_last;

  pll_tab_search #(.N_TAB(N_TAB)) u_search (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (go),
    .req_khz  (req_khz),
    .found    (found),
    .best_set (best_set),
    .req_held (req_held)
  );

  pll_seq_cnt #(.LIMIT(SETTLE_CYC)) u_settle (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (settle_en),
    .last  (settle_last)
  );

  pll_seq_cnt #(.LIMIT(POLL_MAX)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cnt_clr),
    .en    (poll_en),
    .last  (poll_last)
  );

  pll_seq_ctrl #(.INIT_SETTING(INIT_SETTING)) u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .found       (found),
    .best_set    (best_set),
    .pll_lock    (pll_lock),
    .settle_last (settle_last),
    .poll_last   (poll_last),
    .go          (go),
    .cnt_clr     (cnt_clr),
    .settle_en   (settle_en),
    .poll_en     (poll_en),
    .pll_setting (pll_setting),
    .pll_bypass  (pll_bypass),
    .pll_halfpix (pll_halfpix),
    .pll_rst     (pll_rst),
    .pll_wr      (pll_wr),
    .busy        (busy),
    .done        (done),
    .timeout     (timeout)
  );

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(req_held));

endmodule

// File: tb/tb_pxclk_pll_seq.sv
module tb_pxclk_pll_seq;

  localparam int S_CYC = 5000;
  localparam int P_MAX = 1000;
  localparam int N_ENT = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [19:0] req = '0;
  logic        pll_lock = 1'b0;
  logic [31:0] pll_setting;
  logic        pll_bypass, pll_halfpix, pll_rst, pll_wr, busy, done, timeout;

  always #10 clk = ~clk;

  pxclk_pll_seq dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_khz(req), .pll_lock(pll_lock),
    .pll_setting(pll_setting), .pll_bypass(pll_bypass), .pll_halfpix(pll_halfpix),
    .pll_rst(pll_rst), .pll_wr(pll_wr), .busy(busy), .done(done), .timeout(timeout)
  );

  typedef struct {
    logic [31:0] set;
    bit          tmo;
    int          len;
    int          wr;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int n_chk = 0, n_bad = 0, n_done = 0, n_push = 0;
  int hcnt = 0, lock_dly = 10, run_len = 0, run_wr = 0;
  bit          m_locked = 0;
  logic [31:0] m_set = '0;

  function automatic int ref_khz(input int i);
    int f = 6000, st = 1750;
    for (int k = 0; k < i; k++) begin
      f += st;
      st += 500;
    end
    return f;
  endfunction

  function automatic logic [31:0] ref_set(input int i);
    logic [31:0] acc = '0;
    for (int k = 0; k < i; k++) acc += 32'h0000_1A2B;
    return (32'hC3A0_0000 | (acc ^ 32'h0001_0450)) & 32'h0001_7FFF;
  endfunction

  function automatic int ref_pick(input int r);
    int best = 0, bd, d;
    bd = (ref_khz(0) > r) ? ref_khz(0) - r : r - ref_khz(0);
    for (int i = 1; i < N_ENT; i++) begin
      d = (ref_khz(i) > r) ? ref_khz(i) - r : r - ref_khz(i);
      if (d < bd) begin
        bd = d;
        best = i;
      end
    end
    return best;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // monitor, PLL model and counters
  always @(negedge clk) begin
    if (!rst_n) begin
      pll_lock = 1'b0;
      hcnt = 0;
    end else begin
      if (done) begin
        n_done++;
        if (q.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          cur = q.pop_front();
          chk(pll_setting == cur.set, "R2", "masked nearest setting (R1)", pll_setting, cur.set);
          chk(timeout == cur.tmo, "R7", "timeout flag", timeout, cur.tmo);
          chk(run_len == cur.len, "R5", "reset-high cycles (R6)", run_len, cur.len);
          chk(run_wr == cur.wr, "R4", "write strobes (R3)", run_wr, cur.wr);
          chk(!pll_bypass && !pll_halfpix, "R4", "bypass/halfpix cleared",
              {pll_bypass, pll_halfpix}, 0);
          chk(!busy, "R11", "busy low with done", busy, 0);
        end
      end
      if (pll_rst) begin
        run_len++;
        hcnt++;
        pll_lock = (hcnt >= lock_dly);
      end else begin
        hcnt = 0;
      end
      if (pll_wr) run_wr++;
    end
  end

  task automatic run(input int rq, input int dly, input bit intrude);
    exp_t e;
    bit   skip;
    while (busy || done) @(negedge clk);
    e.set = ref_set(ref_pick(rq));
    skip  = m_locked && (m_set == e.set);
    e.wr  = skip ? 0 : 1;
    e.tmo = !skip && (dly > S_CYC + P_MAX);
    if (skip) e.len = 0;
    else if (dly > S_CYC + P_MAX) e.len = S_CYC + P_MAX;
    else if (dly > S_CYC + 1) e.len = dly;
    else e.len = S_CYC + 1;
    @(negedge clk);
    #1;
    lock_dly = dly;
    run_len = 0;
    run_wr = 0;
    q.push_back(e);
    n_push++;
    req = 20'(rq);
    start = 1'b1;
    @(negedge clk);
    chk(busy, "R11", "busy after accepted start", busy, 1);
    chk(!timeout, "R8", "timeout cleared on start", timeout, 0);
    #1 start = 1'b0;
    if (intrude) begin
      repeat (50) @(negedge clk);
      #1;
      req = 20'd84750;
      start = 1'b1;
      @(negedge clk);
      #1 start = 1'b0;
    end
    while (q.size() != 0) @(negedge clk);
    @(negedge clk);
    chk(!done, "R11", "done is one cycle", done, 0);
    if (!skip) m_set = e.set;
    if (!skip) m_locked = !e.tmo;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(!busy && !done && !timeout, "R10", "status in reset", {busy, done, timeout}, 0);
    chk(!pll_rst && !pll_wr, "R10", "reset/strobe in reset", {pll_rst, pll_wr}, 0);
    chk(pll_bypass && !pll_halfpix, "R10", "bypass/halfpix in reset",
        {pll_bypass, pll_halfpix}, 2);
    chk(pll_setting == 32'd0, "R10", "setting in reset", pll_setting, 0);
    #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);

    run(25175, 10, 0);               // R1 nearest, early lock
    run(25175, 10, 0);               // R3 skip: locked, same setting
    run(6875, 10, 0);                // R1 tie goes to lower entry
    run(100000, 1000000, 0);         // R7 never locks -> timeout
    run(100000, S_CYC + 300, 0);     // R8 clear; R3 unlocked -> no skip; R6 mid-poll lock
    run(0, S_CYC + P_MAX, 0);        // R7 lock on the last allowed sample
    run(40000, 10, 1);               // R9 start while busy ignored
    run(84750, S_CYC + 1, 0);        // R5 lock right at first sample

    repeat (20) @(negedge clk);
    chk(n_done == n_push, "R9", "done count", n_done, n_push);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule